// File: doc/BRIEF.md
# Interrupt Priority and Target Register Bank

This block is the configuration store of an interrupt distributor. It holds an 8-bit priority field and an 8-bit processor-target field for every interrupt, packed four fields to a 32-bit word. A host reaches it over a simple memory-mapped bus with per-byte enables. It also exposes a read-only type word and two read-only identification words. Interrupt signalling, arbitration and the processor interface sit elsewhere and only consume the stored fields.

The interrupt count (a multiple of 32), the processor count (1 to 8) and the number of implemented priority bits (4 to 8) are parameters. Storage bits that do not exist read as zero and ignore writes. Unimplemented priority bits are the low-order ones of each field, and target bits above the processor count do not exist. Words past the last implemented interrupt read as zero and ignore writes.

The 12-bit byte address selects a region with bits 11:10: 0 holds the identification words, 1 the priority fields, 2 the target fields, and 3 is unused. Bits 9:2 give the word within the region. Interrupt n sits at region base + n, so its field is in byte lane n mod 4.

Top module: `irq_prio_route_regs`

## Requirements
- R1: After reset, every priority field and every target field reads zero.
- R2: The word at 0x000 reads {24'b0, NUM_CPU-1 in bits 7:5, NUM_IRQ/32-1 in bits 4:0}. With the defaults (64 interrupts, 4 processors) this is 0x61.
- R3: The word at 0x004 reads IMPL_ID and the word at 0x008 reads PERIPH_ID. Writes to 0x000, 0x004 and 0x008 change nothing.
- R4: Priority word k (0x400 + 4k) holds the fields of interrupts 4k to 4k+3 in ascending byte order. Each written byte is ANDed with the mask 8'hFF << (8-PRIO_BITS), the same in every lane. With 5 bits, writing all ones reads 0xF8F8F8F8 and writing 0xFF7FBF3F reads 0xF878B838.
- R5: Target word k (0x800 + 4k) holds one bit per processor in each lane. Bits at or above NUM_CPU read zero and ignore writes. With 4 processors, all ones reads 0x0F0F0F0F and 0x0103020F reads 0x0103020F.
- R6: A write changes only the lanes whose byte enable is set. A write with all four enables updates all four lanes at the same clock edge.
- R7: A read returns zero in every lane whose byte enable is clear.
- R8: These addresses read zero and ignore writes: priority or target words at index NUM_IRQ/4 and above, region 3, and region-0 words at index 3 and above.
- R9: A read request gives rvalid_o high and the data on rdata_o in the following cycle. rvalid_o is low in the cycle after any cycle without a read request.
- R10: A read issued in the cycle directly after a write to the same word returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address, bits 1:0 ignored |
| be_i | input | 4 | Byte-lane enables |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |

## Verification
A write takes effect at the clock edge that accepts it. Read data and rvalid_o appear one edge after the request. The bench drives each access on a falling edge and checks the response on the next falling edge, so it always samples after exactly one rising edge. Accesses run back to back with no idle cycles, so every read also exercises the write-to-read path of R10 against a bench model. In a write cycle, rvalid_o is checked low.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int ADDR_W = 12;

  typedef enum logic [1:0] {
    REG_ID   = 2'd0,
    REG_PRIO = 2'd1,
    REG_TGT  = 2'd2,
    REG_NONE = 2'd3
  } region_e;

  function automatic logic [7:0] prio_mask(int bits);
    return 8'hFF << (8 - bits);
  endfunction

  function automatic logic [7:0] cpu_mask(int cpus);
    return 8'((16'd1 << cpus) - 16'd1);
  endfunction

  function automatic logic [31:0] lane_expand(logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction
endpackage

// File: rtl/irq_id_regs.sv
module irq_id_regs #(
  parameter int          NUM_IRQ   = 64,
  parameter int          NUM_CPU   = 4,
  parameter logic [31:0] IMPL_ID   = 32'h0A51_0017,
  parameter logic [31:0] PERIPH_ID = 32'h0000_0092
) (
  input  logic [7:0]  word_i,
  output logic [31:0] rdata_o
);
  localparam logic [31:0] TYPE_VAL =
      (32'((NUM_IRQ / 32) - 1) & 32'h1F) | ((32'(NUM_CPU - 1) & 32'h7) << 5);

  always_comb begin
    unique case (word_i)
      8'd0:    rdata_o = TYPE_VAL;
      8'd1:    rdata_o = IMPL_ID;
      8'd2:    rdata_o = PERIPH_ID;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_field_bank.sv
module irq_field_bank #(
  parameter int         NUM_WORDS = 16,
  parameter logic [7:0] LANE_MASK = 8'hFF,
  localparam int        IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [3:0]       be_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);
  logic [3:0][7:0] mem [NUM_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NUM_WORDS; w++) mem[w] <= '0;
    end else if (wr_en_i) begin
      for (int l = 0; l < 4; l++)
        if (be_i[l]) mem[idx_i][l] <= wdata_i[8*l +: 8] & LANE_MASK;
    end
  end

  assign rdata_o = mem[idx_i];

  // unimplemented bits never hold a one (R4 for priorities, R5 for targets)
  always_ff @(posedge clk_i) begin
    if (rst_ni)
      for (int w = 0; w < NUM_WORDS; w++)
        assert_lane_mask_R4: assert ((mem[w] & ~{4{LANE_MASK}}) == '0);
  end

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assert_lane_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && !be_i[l] |=> mem[$past(idx_i)][l] == $past(mem[idx_i][l]));
  end
endmodule

// File: rtl/irq_prio_route_regs.sv
module irq_prio_route_regs
  import irq_regs_pkg::*;
#(
  parameter int          NUM_IRQ   = 64,
  parameter int          NUM_CPU   = 4,
  parameter int          PRIO_BITS = 5,
  parameter logic [31:0] IMPL_ID   = 32'h0A51_0017,
  parameter logic [31:0] PERIPH_ID = 32'h0000_0092
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o
);
  localparam int NUM_WORDS = NUM_IRQ / 4;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  region_e     region;
  logic [7:0]  word;
  logic        in_range, rd_req, prio_wr, tgt_wr;
  logic [31:0] id_rd, prio_rd, tgt_rd, rd_word;
  logic        unused_addr;

  assign region      = region_e'(addr_i[ADDR_W-1 -: 2]);
  assign word        = addr_i[ADDR_W-3:2];
  assign unused_addr = ^addr_i[1:0];
  assign in_range    = {1'b0, word} < 9'(NUM_WORDS);
  assign rd_req      = req_i && !we_i;
  assign prio_wr     = req_i && we_i && in_range && region == REG_PRIO;
  assign tgt_wr      = req_i && we_i && in_range && region == REG_TGT;

  irq_id_regs #(
    .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .IMPL_ID(IMPL_ID), .PERIPH_ID(PERIPH_ID)
  ) id_i (
    .word_i (word),
    .rdata_o(id_rd)
  );

  irq_field_bank #(.NUM_WORDS(NUM_WORDS), .LANE_MASK(prio_mask(PRIO_BITS))) prio_i (
    .clk_i, .rst_ni,
    .wr_en_i(prio_wr),
    .idx_i  (word[IDX_W-1:0]),
    .be_i,
    .wdata_i,
    .rdata_o(prio_rd)
  );

  irq_field_bank #(.NUM_WORDS(NUM_WORDS), .LANE_MASK(cpu_mask(NUM_CPU))) tgt_i (
    .clk_i, .rst_ni,
    .wr_en_i(tgt_wr),
    .idx_i  (word[IDX_W-1:0]),
    .be_i,
    .wdata_i,
    .rdata_o(tgt_rd)
  );

  always_comb begin
    unique case (region)
      REG_ID:   rd_word = id_rd;
      REG_PRIO: rd_word = in_range ? prio_rd : '0;
      REG_TGT:  rd_word = in_range ? tgt_rd : '0;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_req;
      if (rd_req) rdata_o <= rd_word & lane_expand(be_i);
    end
  end

  assert_rd_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o);
  assert_no_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rvalid_o);
  assert_lanes_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req && be_i == 4'b0 |=> rdata_o == '0);
  assert_raz_region_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req && region == REG_NONE |=> rdata_o == '0);
  assert_raz_oor_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req && !in_range && region != REG_ID |=> rdata_o == '0);
endmodule

// File: tb/irq_prio_route_regs_tb_top.sv
`timescale 1ns/1ps
module irq_prio_route_regs_tb_top;
  localparam int          NUM_IRQ   = 64;
  localparam int          NUM_CPU   = 4;
  localparam int          PRIO_BITS = 5;
  localparam logic [31:0] IMPL_ID   = 32'h0A51_0017;
  localparam logic [31:0] PERIPH_ID = 32'h0000_0092;
  localparam logic [7:0]  PMASK     = 8'hFF << (8 - PRIO_BITS);
  localparam logic [7:0]  TMASK     = 8'((1 << NUM_CPU) - 1);
  localparam logic [31:0] TYPE_EXP  = 32'((NUM_IRQ / 32) - 1) | (32'(NUM_CPU - 1) << 5);

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic        rvalid;
  logic [31:0] rdata;

  int checks = 0, errors = 0;
  logic [7:0] prio_m [NUM_IRQ];
  logic [7:0] tgt_m  [NUM_IRQ];

  always #2.5 clk = ~clk;

  irq_prio_route_regs #(
    .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .PRIO_BITS(PRIO_BITS),
    .IMPL_ID(IMPL_ID), .PERIPH_ID(PERIPH_ID)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata)
  );

  function automatic logic [31:0] exp_rd(logic [11:0] a, logic [3:0] b);
    logic [31:0] v = '0;
    int w = int'(a[9:2]);
    case (a[11:10])
      2'd0: v = (w == 0) ? TYPE_EXP : (w == 1) ? IMPL_ID : (w == 2) ? PERIPH_ID : '0;
      2'd1: if (w < NUM_IRQ / 4) v = {prio_m[4*w+3], prio_m[4*w+2], prio_m[4*w+1], prio_m[4*w]};
      2'd2: if (w < NUM_IRQ / 4) v = {tgt_m[4*w+3], tgt_m[4*w+2], tgt_m[4*w+1], tgt_m[4*w]};
      default: v = '0;
    endcase
    return v & {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
  endfunction

  task automatic model_wr(logic [11:0] a, logic [3:0] b, logic [31:0] d);
    int w = int'(a[9:2]);
    if (w < NUM_IRQ / 4)
      for (int l = 0; l < 4; l++)
        if (b[l]) begin
          if (a[11:10] == 2'd1) prio_m[4*w+l] = d[8*l +: 8] & PMASK;
          if (a[11:10] == 2'd2) tgt_m[4*w+l]  = d[8*l +: 8] & TMASK;
        end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // called on a falling edge; returns on the next falling edge with inputs still driven
  task automatic bus(logic w, logic [11:0] a, logic [3:0] b, logic [31:0] d, string tag);
    logic [31:0] e;
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    e = exp_rd(a, b);
    if (w) model_wr(a, b, d);
    @(posedge clk);
    @(negedge clk);
    if (w) check("R9", 32'(rvalid), 32'd0);
    else begin
      check("R9", 32'(rvalid), 32'd1);
      check(tag, rdata, e);
    end
  endtask

  initial begin
    #(5ns * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NUM_IRQ; i++) begin prio_m[i] = '0; tgt_m[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", 32'(rvalid), 32'd0);
    // R1 reset state
    bus(0, 12'h400, 4'hF, 0, "R1");
    bus(0, 12'h83C, 4'hF, 0, "R1");
    // R2, R3 identification words
    bus(0, 12'h000, 4'hF, 0, "R2");
    check("R2", rdata, 32'h61);
    bus(0, 12'h004, 4'hF, 0, "R3");
    bus(0, 12'h008, 4'hF, 0, "R3");
    bus(1, 12'h000, 4'hF, 32'hFFFF_FFFF, "R3");
    bus(1, 12'h004, 4'hF, 32'h0, "R3");
    bus(0, 12'h000, 4'hF, 0, "R3");
    check("R3", rdata, TYPE_EXP);
    bus(0, 12'h004, 4'hF, 0, "R3");
    check("R3", rdata, IMPL_ID);
    // R4 masking, R10 back-to-back
    bus(1, 12'h400, 4'hF, 32'hFFFF_FFFF, "R4");
    bus(0, 12'h400, 4'hF, 0, "R10");
    check("R4", rdata, 32'hF8F8_F8F8);
    bus(1, 12'h400, 4'hF, 32'hFF7F_BF3F, "R4");
    bus(0, 12'h400, 4'hF, 0, "R4");
    check("R4", rdata, 32'hF878_B838);
    // R6 single-lane write
    bus(1, 12'h402, 4'b0100, 32'h001F_0000, "R6");
    bus(0, 12'h400, 4'hF, 0, "R6");
    check("R6", rdata, 32'hF818_B838);
    // R7 single-lane read
    bus(0, 12'h400, 4'b0010, 0, "R7");
    check("R7", rdata, 32'h0000_B800);
    bus(0, 12'h400, 4'b0000, 0, "R7");
    // R5 targets
    bus(1, 12'h800, 4'hF, 32'hFFFF_FFFF, "R5");
    bus(0, 12'h800, 4'hF, 0, "R5");
    check("R5", rdata, 32'h0F0F_0F0F);
    bus(1, 12'h800, 4'hF, 32'h0103_020F, "R5");
    bus(0, 12'h800, 4'hF, 0, "R5");
    check("R5", rdata, 32'h0103_020F);
    // R8 boundaries
    bus(1, 12'h43C, 4'hF, 32'hA5A5_5A5A, "R8");
    bus(0, 12'h43C, 4'hF, 0, "R8");
    check("R8", rdata, 32'hA0A0_5858);
    bus(1, 12'h440, 4'hF, 32'hFFFF_FFFF, "R8");
    bus(0, 12'h440, 4'hF, 0, "R8");
    check("R8", rdata, 32'h0);
    bus(1, 12'h840, 4'hF, 32'hFFFF_FFFF, "R8");
    bus(0, 12'h840, 4'hF, 0, "R8");
    bus(0, 12'hC00, 4'hF, 0, "R8");
    bus(0, 12'h00C, 4'hF, 0, "R8");
    // random mix, R6/R10 checked against the model
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      a = {2'($urandom_range(0, 3)), 8'($urandom_range(0, 19)), 2'b00};
      bus(1'($urandom_range(0, 1)), a, 4'($urandom), $urandom, "R10");
    end
    req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9", 32'(rvalid), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule